// File: doc/BRIEF.md
# Parallel Serial-DAC Programming Sequencer

This block loads a group of serial-input DAC devices all at once through one wide output word. It keeps one output bit as a shared serial clock and one as a shared select line. Every remaining bit is the serial data line of one device. A bus elsewhere copies the word into a register on each write strobe. The devices sit on the other side of that register.

To start a frame, the host places one 16-bit instruction per device on a flat input and pulses a start request. The instructions are captured at that moment. Each later write strobe advances the sequence by exactly one word. The first word parks select low with the clock low. Then every instruction bit takes two words. The first word puts the new bit on all data lines with the clock low. The second word keeps those data bits and raises the clock, so the data are settled before the clock edge. After the sixteenth bit, one more word raises select with the clock low. That rising select edge commits the instructions in all devices together. A one-cycle done pulse marks the commit word.

Top module: `pdac_prog_seq`

## Requirements
- R1: After reset, the word has select (bit 1) high, clock (bit 0) low and all data bits low. Done and busy are low.
- R2: A start request while idle captures the instructions and raises busy on the next cycle. The first strobe after that emits the setup word, which has select low, clock low and data all zero.
- R3: Each instruction bit takes two consecutive strobes. The first drives the bit with clock low. The second keeps the same data and drives clock high. Device k sits on word bit k+2 and its instruction is instr_i[16k+15:16k]. Bits go out most significant first, so each device shifts in exactly its own instruction.
- R4: Select stays low in every word from the setup word through the last clock-high word. The clock is never high while select is high.
- R5: The 34th strobe emits the commit word: select high, clock low, data zero. Done is high for exactly the one cycle in which the commit word first appears.
- R6: The word changes only in the cycle after a strobe seen while busy. It changes exactly one step per such strobe, whatever the gaps between strobes.
- R7: A start request while busy is ignored. The frame in progress continues with its originally captured instructions.
- R8: A frame takes exactly 34 strobes while busy: one setup word, 32 shift words and one commit word.
- R9: Busy stays high from the cycle after an accepted start until the commit word appears, and falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request; captures instructions when idle |
| instr_i | input | NDEV*BITS (272) | One instruction per device, device k in slice k |
| wr_tick_i | input | 1 | Word-write strobe; one sequence step per strobe |
| word_o | output | NDEV+2 (19) | Output word: bit 0 clock, bit 1 select, bits 2.. data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse with the commit word |

## Verification
The bench builds the block with its default parameters: 17 devices and 16-bit instructions. At that size every lane of the per-device bit selector and every one of the 16 bit positions is in use. Different instructions per device therefore show any lane swap or bit-order error in the device words the bench rebuilds at each clock rise. The bench varies the strobe spacing (every cycle, every third cycle, random) and also sends starts during a frame and in the same cycle as a strobe. This reaches the step-advance and ignore paths as well as the frame-end edge.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

    // fixed positions inside the output word; the downstream register decodes them
    localparam int CLK_BIT  = 0;
    localparam int SEL_BIT  = 1;
    localparam int DATA_LSB = 2;

    typedef enum logic [1:0] {
        STEP_PREP   = 2'd0,
        STEP_SHIFT  = 2'd1,
        STEP_COMMIT = 2'd2
    } step_e;

endpackage

// File: rtl/pdac_step_ctrl.sv
module pdac_step_ctrl #(
    parameter int BITS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        tick_i,
    output logic                        busy_o,
    output logic                        load_o,
    output logic                        emit_o,
    output pdac_pkg::step_e             kind_o,
    output logic [$clog2(BITS)-1:0]     bit_idx_o,
    output logic                        clk_hi_o
);
    import pdac_pkg::*;

    localparam int LAST   = 2 * BITS + 1;
    localparam int STEP_W = $clog2(LAST + 1);
    localparam int IDX_W  = $clog2(BITS);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d      = q;
        load_o = !q.busy && start_i;
        emit_o = q.busy && tick_i;

        if (q.step == '0)
            kind_o = STEP_PREP;
        else if (q.step == STEP_W'(LAST))
            kind_o = STEP_COMMIT;
        else
            kind_o = STEP_SHIFT;

        // step 1 is bit 0 clock low, step 2 bit 0 clock high, and so on
        bit_idx_o = IDX_W'((q.step - STEP_W'(1)) >> 1);
        clk_hi_o  = !q.step[0];

        if (load_o) begin
            d.busy = 1'b1;
            d.step = '0;
        end else if (emit_o) begin
            if (q.step == STEP_W'(LAST)) begin
                d.busy = 1'b0;
                d.step = '0;
            end else begin
                d.step = q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;

    // R7: with no strobe, a busy sequencer neither restarts nor moves
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !tick_i) |=> (q.busy && $stable(q.step)));

    // R8: the step counter never runs past the commit step
    a_r8_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.step <= STEP_W'(LAST));

    // R9: idle means the counter is parked at zero
    a_r9_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (q.step == '0));

endmodule

// File: rtl/pdac_lane_mux.sv
module pdac_lane_mux #(
    parameter int NDEV = 17,
    parameter int BITS = 16
) (
    input  logic [NDEV*BITS-1:0]    instr_flat,
    input  logic [$clog2(BITS)-1:0] bit_idx,
    output logic [NDEV-1:0]         lanes_o
);
    localparam int IDX_W = $clog2(BITS);

    logic [IDX_W-1:0] pos;

    // most significant bit leaves first
    assign pos = IDX_W'(BITS - 1) - bit_idx;

    for (genvar g = 0; g < NDEV; g++) begin : g_lane
        logic [BITS-1:0] slot;
        assign slot       = instr_flat[g*BITS +: BITS];
        assign lanes_o[g] = slot[pos];
    end

endmodule

// File: rtl/pdac_prog_seq.sv
module pdac_prog_seq #(
    parameter int NDEV = 17,
    parameter int BITS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [NDEV*BITS-1:0]   instr_i,
    input  logic                   wr_tick_i,
    output logic [NDEV+1:0]        word_o,
    output logic                   busy_o,
    output logic                   done_o
);
    import pdac_pkg::*;

    localparam int WORD_W = NDEV + 2;
    localparam int IDX_W  = $clog2(BITS);

    typedef struct packed {
        logic [NDEV*BITS-1:0] shadow;
        logic [WORD_W-1:0]    word;
        logic                 done;
    } top_t;

    top_t q, d;

    logic              load, emit, clk_hi;
    step_e             kind;
    logic [IDX_W-1:0]  bit_idx;
    logic [NDEV-1:0]   lanes;

    pdac_step_ctrl #(.BITS(BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tick_i    (wr_tick_i),
        .busy_o    (busy_o),
        .load_o    (load),
        .emit_o    (emit),
        .kind_o    (kind),
        .bit_idx_o (bit_idx),
        .clk_hi_o  (clk_hi)
    );

    pdac_lane_mux #(.NDEV(NDEV), .BITS(BITS)) u_mux (
        .instr_flat (q.shadow),
        .bit_idx    (bit_idx),
        .lanes_o    (lanes)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (load)
            d.shadow = instr_i;
        if (emit) begin
            d.word = '0;
            unique case (kind)
                STEP_PREP: ;
                STEP_SHIFT: begin
                    d.word[CLK_BIT]               = clk_hi;
                    d.word[WORD_W-1:DATA_LSB]     = lanes;
                end
                STEP_COMMIT: begin
                    d.word[SEL_BIT] = 1'b1;
                    d.done          = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q              <= '0;
            q.word[SEL_BIT] <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign word_o = q.word;
    assign done_o = q.done;

    // R3: data lines never move on the cycle the clock rises
    a_r3_data_held_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.word[CLK_BIT]) |-> $stable(q.word[WORD_W-1:DATA_LSB]));

    // R4: clock high only while select is low
    a_r4_clk_needs_sel_low: assert property (@(posedge clk) disable iff (!rst_n)
        q.word[CLK_BIT] |-> !q.word[SEL_BIT]);

    // R5: done lasts one cycle and comes with the commit word
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    a_r5_done_word: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.word[SEL_BIT] && !q.word[CLK_BIT] && !busy_o));

    // R6: no strobe while busy, no change to the word
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && wr_tick_i) |=> $stable(q.word));

endmodule

// File: tb/pdac_prog_seq_tb.sv
module pdac_prog_seq_tb;

    localparam int NDEV   = 17;
    localparam int BITS   = 16;
    localparam int WORD_W = NDEV + 2;
    localparam int NSTEP  = 2 * BITS + 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start_i = 1'b0;
    logic [NDEV*BITS-1:0]  instr_i = '0;
    logic                  wr_tick_i = 1'b0;
    logic [WORD_W-1:0]     word_o;
    logic                  busy_o, done_o;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;   // 125 MHz

    pdac_prog_seq #(.NDEV(NDEV), .BITS(BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .wr_tick_i(wr_tick_i), .word_o(word_o), .busy_o(busy_o), .done_o(done_o)
    );

    // ---------------- reference model ----------------
    logic [WORD_W-1:0] exp_word;
    bit                exp_busy, exp_done;
    logic [WORD_W-1:0] wq[$];

    function automatic logic [WORD_W-1:0] idle_word();
        logic [WORD_W-1:0] w = '0;
        w[1] = 1'b1;
        return w;
    endfunction

    always @(posedge clk) begin
        exp_done = 1'b0;
        if (!rst_n) begin
            wq.delete();
            exp_busy = 1'b0;
            exp_word = idle_word();
        end else if (exp_busy) begin
            if (wr_tick_i) begin
                exp_word = wq.pop_front();
                if (wq.size() == 0) begin
                    exp_busy = 1'b0;
                    exp_done = 1'b1;
                end
            end
        end else if (start_i) begin
            logic [WORD_W-1:0] w;
            wq.push_back('0);
            for (int b = 0; b < BITS; b++) begin
                w = '0;
                for (int k = 0; k < NDEV; k++)
                    w[2+k] = instr_i[k*BITS + BITS-1-b];
                wq.push_back(w);
                w[0] = 1'b1;
                wq.push_back(w);
            end
            wq.push_back(idle_word());
            exp_busy = 1'b1;
        end
    end

    // ---------------- monitor ----------------
    logic [NDEV*BITS-1:0] golden;
    logic [BITS-1:0]      rebuilt [NDEV];
    int  rise_cnt = 0;
    int  tick_cnt = 0;
    bit  prev_clk = 1'b0;
    bit  monitor_on = 1'b0;

    task automatic check(input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk)
        if (rst_n && wr_tick_i && busy_o) tick_cnt++;

    always @(negedge clk) begin
        if (monitor_on) begin
            // R6 word follows the model step by step; R9 busy; R5 done
            check(exp_done ? "R5" : (exp_word[0] ? "R3" : "R6"),
                  word_o, exp_word, "word");
            check("R9", WORD_W'(busy_o), WORD_W'(exp_busy), "busy");
            check("R5", WORD_W'(done_o), WORD_W'(exp_done), "done");
            if (word_o[0] && !prev_clk) begin
                for (int k = 0; k < NDEV; k++)
                    rebuilt[k] = {rebuilt[k][BITS-2:0], word_o[2+k]};
                rise_cnt++;
                check("R4", WORD_W'(word_o[1]), '0, "select at clock rise");
            end
            if (done_o) begin
                for (int k = 0; k < NDEV; k++)
                    check("R3", WORD_W'(rebuilt[k]), WORD_W'(golden[k*BITS +: BITS]),
                          $sformatf("device %0d word", k));
                check("R3", WORD_W'(rise_cnt), WORD_W'(BITS), "clock rises");
                check("R8", WORD_W'(tick_cnt), WORD_W'(NSTEP), "strobes per frame");
                rise_cnt = 0;
            end
        end
        prev_clk = word_o[0];
    end

    // ---------------- stimulus ----------------
    function automatic logic [NDEV*BITS-1:0] make_instr(input int mode);
        logic [NDEV*BITS-1:0] v;
        for (int k = 0; k < NDEV; k++) begin
            case (mode)
                0: v[k*BITS +: BITS] = '0;
                1: v[k*BITS +: BITS] = '1;
                2: v[k*BITS +: BITS] = (k % 2 == 0) ? 16'hA5C3 : 16'h5A3C;
                3: v[k*BITS +: BITS] = 16'h0001 << (k % BITS);
                default: v[k*BITS +: BITS] = 16'($urandom);
            endcase
        end
        return v;
    endfunction

    task automatic begin_frame(input logic [NDEV*BITS-1:0] v, input bit with_tick);
        @(negedge clk);
        instr_i   = v;
        golden    = v;
        start_i   = 1'b1;
        wr_tick_i = with_tick;   // a strobe with start only captures
        tick_cnt  = 0;
        @(negedge clk);
        start_i   = 1'b0;
        wr_tick_i = 1'b0;
        instr_i   = ~v;          // captured copy must be used
    endtask

    task automatic run_ticks(input int gap_mode, input bit poke_start);
        int n = 0;
        int guard = 0;
        while (!done_o && guard < 2000) begin
            int gap;
            gap = (gap_mode == 0) ? 0 : (gap_mode == 1 ? 2 : int'($urandom_range(0, 3)));
            repeat (gap) @(negedge clk);
            wr_tick_i = 1'b1;
            if (poke_start && n == 10) begin
                start_i = 1'b1;   // R7: ignored while busy
                instr_i = make_instr(4);
            end
            @(negedge clk);
            wr_tick_i = 1'b0;
            start_i   = 1'b0;
            n++;
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        monitor_on = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", word_o, idle_word(), "reset word");
        check("R1", WORD_W'({busy_o, done_o}), '0, "reset busy/done");

        // R2 first strobe gives the setup word
        begin_frame(make_instr(2), 1'b0);
        check("R2", WORD_W'(busy_o), WORD_W'(1), "busy after start");
        wr_tick_i = 1'b1;
        @(negedge clk);
        wr_tick_i = 1'b0;
        check("R2", word_o, '0, "setup word");
        // R6 no strobe, no change
        repeat (3) @(negedge clk);
        check("R6", word_o, '0, "word held without strobe");
        run_ticks(0, 1'b0);

        begin_frame(make_instr(1), 1'b1);
        run_ticks(0, 1'b0);
        begin_frame(make_instr(0), 1'b0);
        run_ticks(1, 1'b0);
        begin_frame(make_instr(3), 1'b0);
        run_ticks(2, 1'b1);        // R7 start during frame
        for (int i = 0; i < 4; i++) begin
            begin_frame(make_instr(4), 1'b0);
            run_ticks(i % 3, i == 2);
        end
        // R7 frame count: idle after last done
        check("R7", WORD_W'(busy_o), '0, "idle after frames");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R6 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule